// File: doc/BRIEF.md
# Flash Program Suspend and Resume Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. It lets the host pause a program operation that is already running in the flash, read from other parts of the array, and then let programming continue. The host tells the block whether a program is running and which sector it targets. It then raises a suspend request, presents read requests one at a time and finally raises a resume request. The block turns these into bus cycles: command writes with a timed write-enable pulse, and array reads with a timed output-enable pulse. It returns the data it reads.

After the suspend command the flash needs a fixed recovery time. The block counts this time in clock cycles and holds back every read until it has passed. A read aimed at the sector whose programming is paused is refused at once with an error pulse and never reaches the bus. The suspend command works the same way when the program was itself started inside an erase suspend. Exactly one resume command is sent per suspend. A new suspend is accepted only once programming has resumed.

Top module: `flash_suspend_seq`

## Requirements
- R1: After reset, write enable and output enable are both high (inactive), `suspended_o`, `rd_done_o` and `rd_err_o` are low, and the address and write data buses are zero.
- R2: A suspend request is accepted only when `prog_busy_i` is high and `suspended_o` is low. It produces one write cycle with data B0h and address zero, and write enable is low for exactly WP_CYC cycles. In any other state the request produces no bus cycle.
- R3: No output-enable cycle starts until at least SETTLE_CYC clock cycles after write enable returns high at the end of the suspend write.
- R4: A read whose sector (the top SECT_W address bits) differs from the paused sector drives its address with output enable low for exactly RD_CYC cycles. It then pulses `rd_done_o` for one cycle with the data that was on `fl_rdata_i` in the last enable cycle.
- R5: A read whose sector equals the value of `prog_sector_i` captured when the suspend was accepted pulses `rd_err_o` for one cycle, does not pulse `rd_done_o`, and causes no output-enable cycle.
- R6: A resume request made while `suspended_o` is high produces one write cycle with data 30h and address zero, with write enable low for WP_CYC cycles. This write comes after any read already in flight has completed. `suspended_o` falls when the write finishes.
- R7: Only one resume write is issued per suspend: further resume requests within the same suspend, and resume requests while not suspended, produce no bus cycle.
- R8: Once a resume write has completed, a new suspend request with `prog_busy_i` high is accepted again.
- R9: Write enable and output enable are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_busy_i | input | 1 | A program operation is running in the flash |
| prog_sector_i | input | SECT_W | Sector targeted by the running program |
| susp_req_i | input | 1 | One-cycle suspend request |
| res_req_i | input | 1 | One-cycle resume request |
| rd_valid_i | input | 1 | Read request valid, held until accepted |
| rd_addr_i | input | AW | Read address |
| rd_ready_o | output | 1 | Read request accepted in this cycle when valid is high |
| rd_done_o | output | 1 | One-cycle pulse: read data valid |
| rd_err_o | output | 1 | One-cycle pulse: read refused (paused sector) |
| rd_data_o | output | DW | Read data |
| suspended_o | output | 1 | High from suspend acceptance until the resume write ends |
| fl_addr_o | output | AW | Flash address bus |
| fl_wdata_o | output | DW | Flash write data |
| fl_we_n_o | output | 1 | Flash write enable, active low |
| fl_oe_n_o | output | 1 | Flash output enable, active low |
| fl_rdata_i | input | DW | Flash read data |

## Verification
The assertions check on every cycle that the two enables never overlap and that no output-enable cycle begins inside the recovery window. They also check that no read reaches the paused sector, that a suspend write follows only a busy program, and that at most one resume write appears per suspend. The bench scenarios show the other behaviours. Returned data must match the responder and exact strobe widths are measured. The bench also shows that suspend and resume requests arriving in the wrong state are dropped, that a resume raised during a read waits for it, and that a fresh suspend works after each resume.

// File: rtl/flash_suspend_pkg.sv
package flash_suspend_pkg;
   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_WR_SUSP = 3'd1,
      ST_SETTLE  = 3'd2,
      ST_HOLD    = 3'd3,
      ST_READ    = 3'd4,
      ST_WR_RES  = 3'd5
   } seq_state_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/fs_down_timer.sv
module fs_down_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/fs_sector_guard.sv
module fs_sector_guard #(
   parameter int  AW          = 16,
   parameter int  SECT_W      = 4,
   parameter bit  BLOCK_SECT  = 1'b1
) (
   input  logic [AW-1:0]     addr,
   input  logic [SECT_W-1:0] paused_sect,
   output logic              hit
);
   if (BLOCK_SECT) begin : g_block
      assign hit = (addr[AW-1 -: SECT_W] == paused_sect);
   end else begin : g_open
      logic unused_ok;
      assign unused_ok = ^{addr, paused_sect};
      assign hit = 1'b0;
   end
endmodule

// File: rtl/flash_suspend_seq.sv
module flash_suspend_seq
   import flash_suspend_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter int SECT_W     = 4,
   parameter int WP_CYC     = 4,
   parameter int RD_CYC     = 5,
   parameter int SETTLE_CYC = 3750,
   parameter bit BLOCK_SECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_busy_i,
   input  logic [SECT_W-1:0] prog_sector_i,
   input  logic              susp_req_i,
   input  logic              res_req_i,
   input  logic              rd_valid_i,
   input  logic [AW-1:0]     rd_addr_i,
   output logic              rd_ready_o,
   output logic              rd_done_o,
   output logic              rd_err_o,
   output logic [DW-1:0]     rd_data_o,
   output logic              suspended_o,
   output logic [AW-1:0]     fl_addr_o,
   output logic [DW-1:0]     fl_wdata_o,
   output logic              fl_we_n_o,
   output logic              fl_oe_n_o,
   input  logic [DW-1:0]     fl_rdata_i
);
   localparam int MAXC = max3(WP_CYC, RD_CYC, SETTLE_CYC);
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] WP_LD  = CW'(WP_CYC - 1);
   localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
   localparam logic [CW-1:0] SET_LD = CW'(SETTLE_CYC - 1);
   localparam logic [DW-1:0] CMD_SUSP = DW'(8'hB0);
   localparam logic [DW-1:0] CMD_RES  = DW'(8'h30);

   if (WP_CYC < 1)              begin : g_bad_wp  $error("WP_CYC must be at least 1"); end
   if (RD_CYC < 1)              begin : g_bad_rd  $error("RD_CYC must be at least 1"); end
   if (SETTLE_CYC < 1)          begin : g_bad_set $error("SETTLE_CYC must be at least 1"); end
   if (DW < 8)                  begin : g_bad_dw  $error("DW must hold an 8-bit command"); end
   if (SECT_W < 1 || SECT_W > AW) begin : g_bad_sw $error("SECT_W out of range"); end

   seq_state_t        st_q, st_d;
   logic              ld;
   logic [CW-1:0]     ld_val;
   logic              t_zero;
   logic              res_pend_q;
   logic [SECT_W-1:0] sect_q;
   logic [AW-1:0]     addr_q;
   logic              hit;
   logic              acc_susp, take_rd;

   fs_down_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .zero(t_zero)
   );

   fs_sector_guard #(.AW(AW), .SECT_W(SECT_W), .BLOCK_SECT(BLOCK_SECT)) u_guard (
      .addr(rd_addr_i), .paused_sect(sect_q), .hit(hit)
   );

   assign acc_susp   = (st_q == ST_RUN) && susp_req_i && prog_busy_i;
   assign rd_ready_o = (st_q == ST_HOLD) && !res_pend_q && !res_req_i;
   assign take_rd    = rd_ready_o && rd_valid_i;

   always_comb begin
      st_d   = st_q;
      ld     = 1'b0;
      ld_val = WP_LD;
      unique case (st_q)
         ST_RUN: if (acc_susp) begin
            st_d = ST_WR_SUSP; ld = 1'b1; ld_val = WP_LD;
         end
         ST_WR_SUSP: if (t_zero) begin
            st_d = ST_SETTLE; ld = 1'b1; ld_val = SET_LD;
         end
         ST_SETTLE: if (t_zero) st_d = ST_HOLD;
         ST_HOLD: begin
            if (res_pend_q || res_req_i) begin
               st_d = ST_WR_RES; ld = 1'b1; ld_val = WP_LD;
            end else if (take_rd && !hit) begin
               st_d = ST_READ; ld = 1'b1; ld_val = RD_LD;
            end
         end
         ST_READ: if (t_zero) st_d = ST_HOLD;
         ST_WR_RES: if (t_zero) st_d = ST_RUN;
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_RUN;
         res_pend_q <= 1'b0;
         sect_q     <= '0;
         addr_q     <= '0;
         rd_done_o  <= 1'b0;
         rd_err_o   <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         st_q      <= st_d;
         rd_done_o <= 1'b0;
         rd_err_o  <= 1'b0;
         if (acc_susp) sect_q <= prog_sector_i;
         if (st_d == ST_WR_RES)
            res_pend_q <= 1'b0;
         else if (res_req_i && st_q != ST_RUN && st_q != ST_WR_RES)
            res_pend_q <= 1'b1;
         if (take_rd) begin
            if (hit) rd_err_o <= 1'b1;
            else     addr_q   <= rd_addr_i;
         end
         if (st_q == ST_READ && t_zero) begin
            rd_done_o <= 1'b1;
            rd_data_o <= fl_rdata_i;
         end
      end
   end

   assign suspended_o = (st_q != ST_RUN);
   assign fl_we_n_o   = !((st_q == ST_WR_SUSP) || (st_q == ST_WR_RES));
   assign fl_oe_n_o   = (st_q != ST_READ);
   assign fl_addr_o   = (st_q == ST_READ) ? addr_q : '0;
   assign fl_wdata_o  = (st_q == ST_WR_SUSP) ? CMD_SUSP :
                        (st_q == ST_WR_RES)  ? CMD_RES  : '0;
endmodule

// File: rtl/flash_suspend_seq_chk.sv
module flash_suspend_seq_chk #(
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter int SECT_W     = 4,
   parameter int SETTLE_CYC = 3750,
   parameter bit BLOCK_SECT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prog_busy_i,
   input logic [SECT_W-1:0] prog_sector_i,
   input logic              susp_req_i,
   input logic              suspended_o,
   input logic [AW-1:0]     fl_addr_o,
   input logic [DW-1:0]     fl_wdata_o,
   input logic              fl_we_n_o,
   input logic              fl_oe_n_o
);
   localparam int GW = $clog2(SETTLE_CYC + 1) + 1;
   localparam logic [DW-1:0] C_SUSP = DW'(8'hB0);
   localparam logic [DW-1:0] C_RES  = DW'(8'h30);

   logic [GW-1:0]     gap_q;
   logic [SECT_W-1:0] sect_q;
   logic              res_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q      <= GW'(SETTLE_CYC);
         sect_q     <= '0;
         res_seen_q <= 1'b0;
      end else begin
         if (!fl_we_n_o && fl_wdata_o == C_SUSP) gap_q <= '0;
         else if (gap_q < GW'(SETTLE_CYC))       gap_q <= gap_q + 1'b1;
         if (susp_req_i && prog_busy_i && !suspended_o) sect_q <= prog_sector_i;
         if (!fl_we_n_o && fl_wdata_o == C_SUSP)  res_seen_q <= 1'b0;
         else if (!fl_we_n_o && fl_wdata_o == C_RES) res_seen_q <= 1'b1;
      end
   end

   a_r9_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n_o && !fl_oe_n_o));

   a_r3_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n_o |-> gap_q >= GW'(SETTLE_CYC));

   a_r5_no_paused_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_oe_n_o && BLOCK_SECT) |-> fl_addr_o[AW-1 -: SECT_W] != sect_q);

   a_r2_suspend_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(fl_we_n_o) && fl_wdata_o == C_SUSP) |-> $past(prog_busy_i));

   a_r7_single_resume: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(fl_we_n_o) && fl_wdata_o == C_RES) |-> !res_seen_q);
endmodule

bind flash_suspend_seq flash_suspend_seq_chk #(
   .AW(AW), .DW(DW), .SECT_W(SECT_W), .SETTLE_CYC(SETTLE_CYC), .BLOCK_SECT(BLOCK_SECT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .prog_busy_i(prog_busy_i), .prog_sector_i(prog_sector_i),
   .susp_req_i(susp_req_i), .suspended_o(suspended_o), .fl_addr_o(fl_addr_o),
   .fl_wdata_o(fl_wdata_o), .fl_we_n_o(fl_we_n_o), .fl_oe_n_o(fl_oe_n_o)
);

// File: tb/tb_flash_suspend_seq.sv
`timescale 1ns/1ps
module tb_flash_suspend_seq;
   localparam int AW = 16, DW = 16, SW = 4;
   localparam int WP = 4, RDC = 5, SETTLE = 3750;

   logic clk = 0, rst_n = 0;
   logic prog_busy = 0, susp_req = 0, res_req = 0, rd_valid = 0;
   logic [SW-1:0] prog_sect = '0;
   logic [AW-1:0] rd_addr = '0;
   logic rd_ready, rd_done, rd_err, suspended, we_n, oe_n;
   logic [DW-1:0] rd_data, wdata, rdata;
   logic [AW-1:0] fl_addr;

   int n_tests = 0, n_fail = 0;
   int susp_wr = 0, res_wr = 0, other_wr = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   function automatic logic [DW-1:0] flash_word(input logic [AW-1:0] a);
      return (a * 16'h9E37) ^ 16'h5A5A;
   endfunction

   assign rdata = flash_word(fl_addr);

   flash_suspend_seq #(.AW(AW), .DW(DW), .SECT_W(SW), .WP_CYC(WP), .RD_CYC(RDC),
                       .SETTLE_CYC(SETTLE)) dut (
      .clk(clk), .rst_n(rst_n), .prog_busy_i(prog_busy), .prog_sector_i(prog_sect),
      .susp_req_i(susp_req), .res_req_i(res_req), .rd_valid_i(rd_valid),
      .rd_addr_i(rd_addr), .rd_ready_o(rd_ready), .rd_done_o(rd_done),
      .rd_err_o(rd_err), .rd_data_o(rd_data), .suspended_o(suspended),
      .fl_addr_o(fl_addr), .fl_wdata_o(wdata), .fl_we_n_o(we_n), .fl_oe_n_o(oe_n),
      .fl_rdata_i(rdata));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // bus monitor
   int we_w = 0, oe_w = 0, gap = 0, oe_cnt = 0;
   bit prev_we = 1, prev_oe = 1, armed = 0;
   logic [DW-1:0] last_wd = '0;
   logic [SW-1:0] paused = '0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (!we_n && !oe_n) check(0, "R9", "enables overlap", 1, 0);
         if (!we_n) begin
            if (prev_we) begin
               we_w = 0; last_wd = wdata;
               if (wdata == 16'h00B0) susp_wr++;
               else if (wdata == 16'h0030) res_wr++;
               else other_wr++;
               check(fl_addr == 0, "R2", "command address", int'(fl_addr), 0);
            end
            we_w++;
         end else if (!prev_we) begin
            check(we_w == WP, (last_wd == 16'h00B0) ? "R2" : "R6", "write pulse width", we_w, WP);
            if (last_wd == 16'h00B0) begin gap = 0; armed = 1; end
         end else if (armed) gap++;
         if (!oe_n) begin
            if (prev_oe) begin
               oe_w = 0; oe_cnt++;
               if (armed) begin
                  check(gap >= SETTLE, "R3", "settle gap before read", gap, SETTLE);
                  armed = 0;
               end
               check(fl_addr[AW-1 -: SW] != paused, "R5", "paused sector on bus",
                     int'(fl_addr[AW-1 -: SW]), -1);
            end
            oe_w++;
         end else if (!prev_oe) begin
            check(oe_w == RDC, "R4", "read pulse width", oe_w, RDC);
         end
      end
      prev_we = we_n; prev_oe = oe_n;
   end

   task automatic pulse_susp();
      @(negedge clk); susp_req = 1; @(negedge clk); susp_req = 0;
   endtask
   task automatic pulse_res();
      @(negedge clk); res_req = 1; @(negedge clk); res_req = 0;
   endtask

   // issue a read; optionally raise resume while it is on the bus
   task automatic do_read(input logic [AW-1:0] a, input bit res_mid);
      bit blocked = (a[AW-1 -: SW] == paused);
      bit got_done = 0, got_err = 0;
      logic [DW-1:0] d = '0;
      int oe_before = oe_cnt;
      @(negedge clk); rd_addr = a; rd_valid = 1;
      while (!rd_ready) @(negedge clk);
      @(negedge clk); rd_valid = 0;
      if (res_mid) begin res_req = 1; @(negedge clk); res_req = 0; end
      for (int i = 0; i < 40 && !got_done && !got_err; i++) begin
         if (rd_done) begin got_done = 1; d = rd_data; end
         if (rd_err) got_err = 1;
         if (!got_done && !got_err) @(negedge clk);
      end
      if (blocked) begin
         check(got_err && !got_done, "R5", "paused-sector read refused", got_err, 1);
         check(oe_cnt == oe_before, "R5", "no read strobe", oe_cnt - oe_before, 0);
      end else begin
         check(got_done && !got_err, "R4", "read completed", got_done, 1);
         check(d == flash_word(a), "R4", "read data", int'(d), int'(flash_word(a)));
      end
   endtask

   initial begin
      int sw0, rw0;
      void'($urandom(32'h1F2E));
      // R1 reset state
      repeat (3) @(negedge clk);
      check(we_n && oe_n, "R1", "enables idle in reset", {we_n, oe_n}, 3);
      rst_n = 1;
      @(negedge clk);
      check(!suspended && !rd_done && !rd_err, "R1", "status low after reset",
            {suspended, rd_done, rd_err}, 0);
      check(fl_addr == 0 && wdata == 0, "R1", "buses zero", int'(fl_addr), 0);

      // R2 suspend without a running program is ignored
      pulse_susp(); repeat (10) @(negedge clk);
      check(susp_wr == 0 && !suspended, "R2", "suspend while idle ignored", susp_wr, 0);
      // R7 resume while not suspended is ignored
      pulse_res(); repeat (10) @(negedge clk);
      check(res_wr == 0, "R7", "resume while running ignored", res_wr, 0);

      for (int round = 0; round < 4; round++) begin
         prog_busy = 1;
         prog_sect = SW'($urandom_range(0, 15));
         paused = prog_sect;
         sw0 = susp_wr; rw0 = res_wr;
         pulse_susp();
         check(suspended, "R8", "suspend accepted", suspended, 1);
         prog_sect = ~paused; // later changes must not move the paused sector
         repeat (WP + 2) @(negedge clk);
         check(susp_wr == sw0 + 1, "R2", "one B0h write", susp_wr - sw0, 1);
         pulse_susp(); // second suspend while suspended
         // R3/R4: read requested at once, must wait out the settle window
         do_read({($urandom_range(0, 1) ? paused + 4'd1 : paused - 4'd1),
                  12'($urandom)}, 0);
         do_read({paused, 12'($urandom)}, 0);
         for (int k = 0; k < int'($urandom_range(2, 5)); k++)
            do_read({4'($urandom), 12'($urandom)}, 0);
         check(susp_wr == sw0 + 1, "R2", "suspend while suspended ignored", susp_wr - sw0, 1);
         if (round[0]) begin
            do_read({paused ^ 4'h8, 12'($urandom)}, 1); // R6 resume during read
         end else begin
            pulse_res();
         end
         pulse_res(); // R7 extra resume within same suspend
         for (int t = 0; t < 50 && suspended; t++) @(negedge clk);
         check(!suspended, "R6", "suspended cleared after resume", suspended, 0);
         repeat (5) @(negedge clk);
         check(res_wr == rw0 + 1, "R7", "exactly one 30h write", res_wr - rw0, 1);
         pulse_res(); repeat (8) @(negedge clk);
         check(res_wr == rw0 + 1, "R7", "resume after resume ignored", res_wr - rw0, 1);
      end
      check(other_wr == 0, "R2", "no unexpected command data", other_wr, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      check(0, "R1", "watchdog expired", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule